// File: doc/BRIEF.md
# IDE PIO Register Access Sequencer

This block runs single programmed-I/O register accesses from a host to a disk device working in True IDE mode. A local requester presents one request at a time. Each request carries a direction, a four-bit register select, a byte/word flag and write data. The sequencer latches the request and drives the two active-low chip selects, the three-bit device address, the read or write strobe and the data-bus output enable. When the access ends it returns the read data and a one-cycle done pulse.

Every phase of the access is counted in system clocks. Each count is derived by rounding up a nanosecond minimum against the clock period, so all timing stays parametric. The phases are address and select setup, strobe, and hold. The device's active-low wait line keeps the strobe asserted for as long as the device needs. A request that arrives while an access is running is held off with a ready-low handshake.

Top module: `idePioSeq`

## Requirements
- R1: During reset and directly after it, both chip selects and both strobes are high, the output enable is low, reqReady is high and done is low.
- R2: A select with bit 3 clear reaches the task-file block (data register at 0, task registers at 1 to 7). csTaskN is low, csCtrlN is high and ideAddr equals select bits 2..0 throughout the access.
- R3: A select with bit 3 set reaches the control block. csTaskN is high, csCtrlN is low and ideAddr is 6 throughout the access, whatever select bits 2..0 hold.
- R4: Both chip selects are never low together. Outside the setup, strobe and hold phases, including the done cycle, both are high.
- R5: Chip select and address are driven for exactly ceil(max(70 ns, 5 ns)/period) clocks (9 at 8 ns) before the strobe falls.
- R6: With wait high, the strobe stays low for exactly ceil(max(165 ns, 100 ns)/period) clocks (21 at 8 ns).
- R7: While ideWaitN is sampled low, the strobe stays low. If the device holds wait low for W strobe cycles, the strobe lasts max(21, W) clocks.
- R8: After the strobe rises, chip select and address are held for exactly ceil(20 ns/period) clocks (3 at 8 ns). The next cycle is the done cycle.
- R9: Reads pulse only ideRdN and writes pulse only ideWrN. The two strobes are never low together.
- R10: For writes, ideDataOe is high and ideDataOut carries the latched write data from the first setup cycle through the last hold cycle. Bits 7..0 are checked on byte writes and all 16 bits on word writes. For reads, ideDataOe stays low.
- R11: Read data is sampled on the clock edge that ends the strobe. A word access returns all 16 bits; a byte access returns bits 7..0 with the upper byte zero. The value holds after done.
- R12: reqReady is high only while idle. Request fields that change after acceptance have no effect on the running access.
- R13: done is high for exactly one clock per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request accepted when both high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSel | input | 4 | Bit 3: control block; bits 2..0: task-file address |
| reqWord | input | 1 | 1 = 16-bit transfer, 0 = 8-bit |
| reqWrData | input | 16 | Write data |
| rdData | output | 16 | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| csTaskN | output | 1 | Task-file chip select, active low |
| csCtrlN | output | 1 | Control-block chip select, active low |
| ideAddr | output | 3 | Device register address |
| ideRdN | output | 1 | Read strobe, active low |
| ideWrN | output | 1 | Write strobe, active low |
| ideWaitN | input | 1 | Device wait, low = extend strobe |
| ideDataOut | output | 16 | Data driven toward the device |
| ideDataOe | output | 1 | Output enable for ideDataOut |
| ideDataIn | input | 16 | Data from the device |

## Verification
The bench counts every phase of each access at the ports. A miscounted setup or hold load would show up as a phase one clock too short or too long. Wait lengths below, equal to and above the minimum width test whether the strobe obeys both the counter and the wait line. A design that gave wait priority would release early, and one that ignored wait would release at 21 cycles. The model device drives invalid data on the bus until 100 ns into the strobe and again as soon as the strobe rises, so capturing in the hold phase or too early returns a wrong value. Request fields are scrambled after acceptance, which exposes a design that decodes chip selects or data from the live inputs instead of latched copies.

// File: rtl/idePioPkg.sv
package idePioPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } phaseT;

  // Strobes from the sequencer control to the datapath
  typedef struct packed {
    logic loadReq;   // latch the incoming request
    logic select;    // chip select and address active
    logic strobe;    // read or write strobe active
    logic capture;   // sample read data this edge
    logic finish;    // completion cycle
  } dpCtrlT;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/idePioCtrl.sv
module idePioCtrl
  import idePioPkg::*;
#(
  parameter int SETUP_CYC  = 9,
  parameter int STROBE_CYC = 21,
  parameter int HOLD_CYC   = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   waitN,
  output logic   reqReady,
  output dpCtrlT ctl
);

  localparam int MAX_CYC = maxOf(maxOf(SETUP_CYC, STROBE_CYC), HOLD_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

  phaseT            phase;
  logic [CNT_W-1:0] cnt;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase <= PH_SETUP;
            cnt   <= SETUP_LD;
          end
        end
        PH_SETUP: begin
          if (cntZero) begin
            phase <= PH_STROBE;
            cnt   <= STROBE_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (!cntZero) begin
            cnt <= cnt - 1'b1;
          end else if (waitN) begin
            phase <= PH_HOLD;
            cnt   <= HOLD_LD;
          end
        end
        PH_HOLD: begin
          if (cntZero) phase <= PH_DONE;
          else         cnt   <= cnt - 1'b1;
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady    = (phase == PH_IDLE);
    ctl.loadReq = (phase == PH_IDLE) && reqValid;
    ctl.select  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    ctl.strobe  = (phase == PH_STROBE);
    ctl.capture = (phase == PH_STROBE) && cntZero && waitN;
    ctl.finish  = (phase == PH_DONE);
  end

  // R7
  wait_extends_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE && !waitN) |=> (phase == PH_STROBE));

  // R12
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R8
  hold_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == PH_STROBE && phase != PH_STROBE) |-> (phase == PH_HOLD));

endmodule

// File: rtl/idePioDatapath.sv
module idePioDatapath
  import idePioPkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W:0]   reqSel,
  input  logic              reqWord,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] ideDataIn,
  output logic              csTaskN,
  output logic              csCtrlN,
  output logic [ADDR_W-1:0] ideAddr,
  output logic              ideRdN,
  output logic              ideWrN,
  output logic [DATA_W-1:0] ideDataOut,
  output logic              ideDataOe,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  localparam int BYTE_W = DATA_W / 2;

  logic              isWr;
  logic              isCtrl;
  logic              isWord;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isWr    <= 1'b0;
      isCtrl  <= 1'b0;
      isWord  <= 1'b0;
      addrQ   <= '0;
      wrDataQ <= '0;
      rdData  <= '0;
    end else begin
      if (ctl.loadReq) begin
        isWr    <= reqWrite;
        isCtrl  <= reqSel[ADDR_W];
        isWord  <= reqWord;
        addrQ   <= reqSel[ADDR_W-1:0];
        wrDataQ <= reqWrData;
      end
      if (ctl.capture && !isWr) begin
        rdData <= isWord ? ideDataIn : {{BYTE_W{1'b0}}, ideDataIn[BYTE_W-1:0]};
      end
    end
  end

  always_comb begin
    csTaskN    = !(ctl.select && !isCtrl);
    csCtrlN    = !(ctl.select && isCtrl);
    ideAddr    = isCtrl ? ADDR_W'(CTRL_ADDR) : addrQ;
    ideRdN     = !(ctl.strobe && !isWr);
    ideWrN     = !(ctl.strobe && isWr);
    ideDataOe  = ctl.select && isWr;
    ideDataOut = wrDataQ;
    done       = ctl.finish;
  end

  // R4
  no_dual_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csTaskN || csCtrlN));

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ideRdN || ideWrN));

  // R10
  oe_inside_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    ideDataOe |-> (!csTaskN || !csCtrlN));

  // R13
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/idePioSeq.sv
module idePioSeq
  import idePioPkg::*;
#(
  parameter int CLK_PERIOD_NS   = 8,
  parameter int T_ADDR_SETUP_NS = 70,
  parameter int T_CS_SETUP_NS   = 5,
  parameter int T_STROBE_NS     = 165,
  parameter int T_DATA_VALID_NS = 100,
  parameter int T_ADDR_HOLD_NS  = 20,
  parameter int T_CS_HOLD_NS    = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [3:0]  reqSel,
  input  logic        reqWord,
  input  logic [15:0] reqWrData,
  output logic [15:0] rdData,
  output logic        done,
  output logic        csTaskN,
  output logic        csCtrlN,
  output logic [2:0]  ideAddr,
  output logic        ideRdN,
  output logic        ideWrN,
  input  logic        ideWaitN,
  output logic [15:0] ideDataOut,
  output logic        ideDataOe,
  input  logic [15:0] ideDataIn
);

  localparam int SETUP_CYC  = maxOf(1, ceilDiv(maxOf(T_ADDR_SETUP_NS, T_CS_SETUP_NS), CLK_PERIOD_NS));
  localparam int STROBE_CYC = maxOf(1, ceilDiv(maxOf(T_STROBE_NS, T_DATA_VALID_NS), CLK_PERIOD_NS));
  localparam int HOLD_CYC   = maxOf(1, ceilDiv(maxOf(T_ADDR_HOLD_NS, T_CS_HOLD_NS), CLK_PERIOD_NS));

  dpCtrlT ctl;

  idePioCtrl #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .waitN   (ideWaitN),
    .reqReady(reqReady),
    .ctl     (ctl)
  );

  idePioDatapath #(
    .DATA_W   (16),
    .ADDR_W   (3),
    .CTRL_ADDR(6)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqWrite  (reqWrite),
    .reqSel    (reqSel),
    .reqWord   (reqWord),
    .reqWrData (reqWrData),
    .ideDataIn (ideDataIn),
    .csTaskN   (csTaskN),
    .csCtrlN   (csCtrlN),
    .ideAddr   (ideAddr),
    .ideRdN    (ideRdN),
    .ideWrN    (ideWrN),
    .ideDataOut(ideDataOut),
    .ideDataOe (ideDataOe),
    .rdData    (rdData),
    .done      (done)
  );

endmodule

// File: tb/sim_idePioSeq.sv
module sim_idePioSeq;

  localparam int PER_NS    = 8;
  localparam int SETUP_EXP = (70 + PER_NS - 1) / PER_NS;
  localparam int STRB_EXP  = (165 + PER_NS - 1) / PER_NS;
  localparam int VALID_CYC = (100 + PER_NS - 1) / PER_NS;
  localparam int HOLD_EXP  = (20 + PER_NS - 1) / PER_NS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [3:0]  reqSel = '0;
  logic        reqWord = 1'b0;
  logic [15:0] reqWrData = '0;
  logic        ideWaitN = 1'b1;
  logic [15:0] ideDataIn = '0;
  logic        reqReady, done, csTaskN, csCtrlN, ideRdN, ideWrN, ideDataOe;
  logic [15:0] rdData, ideDataOut;
  logic [2:0]  ideAddr;

  int nCmp = 0;
  int nBad = 0;
  bit finishedRun = 1'b0;

  always #4 clk = ~clk;

  idePioSeq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSel(reqSel), .reqWord(reqWord), .reqWrData(reqWrData),
    .rdData(rdData), .done(done), .csTaskN(csTaskN), .csCtrlN(csCtrlN),
    .ideAddr(ideAddr), .ideRdN(ideRdN), .ideWrN(ideWrN), .ideWaitN(ideWaitN),
    .ideDataOut(ideDataOut), .ideDataOe(ideDataOe), .ideDataIn(ideDataIn)
  );

  function automatic logic [15:0] devVal(input logic [2:0] a, input logic ctrlBlk);
    return 16'hA5C3 ^ (16'(a) * 16'h1357) ^ (ctrlBlk ? 16'h0FF0 : 16'h0000);
  endfunction

  function automatic int expStrobe(input int w);
    return (w > STRB_EXP) ? w : STRB_EXP;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge with the sequencer idle; returns at a negedge, idle again.
  task automatic doAccess(input bit wr, input logic [3:0] sel, input bit word,
                          input logic [15:0] wd, input int w);
    logic        ctrlBlk;
    logic [2:0]  expAddr;
    logic [15:0] dv, expRd;
    int          setupC, strobeC, holdC;
    bit          seenStb, fin, stb;
    ctrlBlk = sel[3];
    expAddr = ctrlBlk ? 3'd6 : sel[2:0];
    dv      = devVal(expAddr, ctrlBlk);
    expRd   = word ? dv : {8'h00, dv[7:0]};
    setupC = 0; strobeC = 0; holdC = 0; seenStb = 0; fin = 0;
    chk(reqReady == 1'b1, "R12 ready while idle", 32'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqSel = sel; reqWord = word; reqWrData = wd;
    ideWaitN = 1'b1; ideDataIn = ~dv;
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = 1'($urandom); reqSel = 4'($urandom); reqWord = 1'($urandom);
    reqWrData = 16'($urandom);
    for (int i = 0; i < 300 && !fin; i++) begin
      if (done) begin
        fin = 1'b1;
      end else begin
        stb = !ideRdN || !ideWrN;
        if (stb) begin
          strobeC++;
          seenStb = 1'b1;
          chk(wr ? (!ideWrN && ideRdN) : (!ideRdN && ideWrN), "R9 strobe polarity",
              {ideRdN, ideWrN}, wr ? 2'b10 : 2'b01);
          ideWaitN  = (strobeC >= w);
          ideDataIn = (strobeC >= VALID_CYC) ? dv : ~dv;
        end else begin
          ideWaitN  = 1'b1;
          ideDataIn = dv ^ 16'h5A5A;
          if (seenStb) holdC++;
          else         setupC++;
        end
        if (ctrlBlk)
          chk(csTaskN && !csCtrlN, "R3 control select", {csTaskN, csCtrlN}, 2'b10);
        else
          chk(!csTaskN && csCtrlN, "R2 task select", {csTaskN, csCtrlN}, 2'b01);
        chk(ideAddr == expAddr, ctrlBlk ? "R3 address" : "R2 address", 32'(ideAddr), 32'(expAddr));
        chk(reqReady == 1'b0, "R12 ready while busy", 32'(reqReady), 0);
        chk(ideDataOe == wr, "R10 output enable", 32'(ideDataOe), 32'(wr));
        if (wr) begin
          if (word) chk(ideDataOut == wd, "R10 word data", 32'(ideDataOut), 32'(wd));
          else      chk(ideDataOut[7:0] == wd[7:0], "R10 byte data", 32'(ideDataOut[7:0]), 32'(wd[7:0]));
        end
        @(negedge clk);
      end
    end
    chk(fin, "R8 done reached", 32'(fin), 1);
    chk(csTaskN && csCtrlN, "R4 standby at done", {csTaskN, csCtrlN}, 2'b11);
    chk(ideRdN && ideWrN && !ideDataOe, "R4 strobes idle at done", {ideRdN, ideWrN, ideDataOe}, 3'b110);
    chk(setupC == SETUP_EXP, "R5 setup cycles", setupC, SETUP_EXP);
    if (w > STRB_EXP)
      chk(strobeC == expStrobe(w), "R7 wait stretched strobe", strobeC, expStrobe(w));
    else
      chk(strobeC == STRB_EXP, "R6 strobe cycles", strobeC, STRB_EXP);
    chk(holdC == HOLD_EXP, "R8 hold cycles", holdC, HOLD_EXP);
    if (!wr) chk(rdData == expRd, "R11 read data", rdData, expRd);
    @(negedge clk);
    chk(done == 1'b0, "R13 done one cycle", 32'(done), 0);
    chk(reqReady == 1'b1, "R12 ready after done", 32'(reqReady), 1);
    if (!wr) chk(rdData == expRd, "R11 read data held", rdData, expRd);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1
    chk(csTaskN && csCtrlN, "R1 reset selects", {csTaskN, csCtrlN}, 2'b11);
    chk(ideRdN && ideWrN, "R1 reset strobes", {ideRdN, ideWrN}, 2'b11);
    chk(!ideDataOe && !done && reqReady, "R1 reset oe/done/ready", {ideDataOe, done, reqReady}, 3'b001);
    rstN = 1'b1;
    @(negedge clk);
    chk(csTaskN && csCtrlN && reqReady, "R1 after reset", {csTaskN, csCtrlN, reqReady}, 3'b111);

    doAccess(1'b0, 4'h0, 1'b1, 16'h0000, 0);
    doAccess(1'b1, 4'h0, 1'b1, 16'hBEEF, 0);
    doAccess(1'b1, 4'h3, 1'b0, 16'h12C4, 0);
    doAccess(1'b0, 4'h7, 1'b0, 16'h0000, 5);
    doAccess(1'b1, 4'hE, 1'b0, 16'h0006, 0);
    doAccess(1'b0, 4'h9, 1'b0, 16'h0000, 0);
    doAccess(1'b0, 4'h2, 1'b1, 16'h0000, STRB_EXP);
    doAccess(1'b0, 4'h1, 1'b1, 16'h0000, STRB_EXP + 1);
    doAccess(1'b1, 4'h5, 1'b1, 16'h55AA, 40);
    for (int k = 0; k < 60; k++) begin
      int wr;
      wr = $urandom_range(0, 3);
      doAccess(1'(wr), 4'($urandom), 1'($urandom), 16'($urandom),
               (wr == 0) ? 0 : $urandom_range(0, 34));
    end
    finishedRun = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finishedRun) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule